// File: doc/BRIEF.md
# Trap Vector Base Register with Write Legalization

This block holds the base address and entry mode that a processor core uses when it takes a trap. Software updates it through a CSR-style port that can replace, set bits in, or clear bits in the stored value. The raw result of each operation is turned into a legal value before it is stored, so the register can never hold a value the core cannot use. An illegal write never produces a fault; it is quietly repaired or dropped.

The two low bits are the entry mode: `00` means every trap enters at the base, and `01` means interrupts enter at the base plus four times their cause number. Encodings with bit 1 set are not legal. Parameters choose what happens to them: drop the whole write, clear only bit 1, or force the mode to `00`. A parameter can also tie the mode to `00` for cores without vectored interrupts. Another parameter widens the forced-zero region of the base, for example to a 64-byte line or a 4 KiB page. The block also produces the trap target address on every cycle from the stored value and the trap kind and cause. The mode bits never take part in the address sum.

Top module: `tvec_reg`

## Requirements
- R1: After reset the register reads RST_VEC with its bits below ALIGN_LSB cleared, and the mode is 00.
- R2: wr_op selects the raw value when wr_en is 1: 2'b01 replaces it with wr_data, 2'b10 ORs wr_data into the old value, 2'b11 clears the bits that are set in wr_data, and 2'b00 leaves the register unchanged. A write takes effect at the next rising clock edge. When wr_en is 0 the register holds its value.
- R3: Stored bits [ALIGN_LSB-1:2] are always zero, whatever the mode. ALIGN_LSB is 2, 6 or 12.
- R4: With MODE_POLICY 0, a raw value whose mode bit 1 is set leaves the whole register unchanged.
- R5: With MODE_POLICY 1, a raw mode of 2'b10 is stored as 2'b00 and 2'b11 as 2'b01. The base is legalized as usual.
- R6: With MODE_POLICY 2, a raw mode with bit 1 set is stored as 2'b00. The base is legalized as usual.
- R7: With DIRECT_ONLY 1, the stored mode is always 2'b00, and this takes precedence over MODE_POLICY.
- R8: When the stored mode is 2'b00, or the trap is a synchronous exception (trap_irq 0), trap_target equals the stored value with bits [1:0] cleared.
- R9: When the stored mode is 2'b01 and trap_irq is 1, trap_target equals the stored base plus four times trap_cause.
- R10: Bits [1:0] of trap_target are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | Operation: 01 replace, 10 set bits, 11 clear bits, 00 none |
| wr_data | input | XLEN | Write operand |
| rd_data | output | XLEN | Stored, legalized value |
| trap_irq | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| trap_cause | input | CAUSE_W | Cause number of the trap |
| trap_target | output | XLEN | Address of the first handler instruction |

## Verification
On every cycle the assertions check that the stored mode is legal, that the forced-zero base bits stay zero, that trap targets are word aligned, and that an idle port or a dropped illegal write leaves the register unchanged. The exact values depend on the operation, the policy and the alignment, and only the bench's scenarios can show them. The bench drives four differently parameterized instances with the same sweep of operations and operand patterns and compares each one with an arithmetic model. It also sweeps every cause number for both trap kinds, with the stored mode at 00 and at 01.

// File: rtl/tvec_reg.sv
module tvec_reg #(
  parameter int               XLEN        = 32,
  parameter int               CAUSE_W     = 6,
  parameter logic [XLEN-1:0]  RST_VEC     = 32'h0000_1000,
  parameter int               MODE_POLICY = 0,
  parameter bit               DIRECT_ONLY = 1'b0,
  parameter int               ALIGN_LSB   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_op,
  input  logic [XLEN-1:0]    wr_data,
  output logic [XLEN-1:0]    rd_data,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_target
);

  localparam logic [XLEN-1:0] LOW_MASK  = (XLEN'(1) << ALIGN_LSB) - XLEN'(1);
  localparam logic [XLEN-1:0] RST_LEGAL = RST_VEC & ~LOW_MASK;

  logic [XLEN-1:0] vec_q;
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] legal;
  logic [1:0]      mode_l;
  logic            drop;

  always_comb begin
    unique case (wr_op)
      2'b01:   raw = wr_data;
      2'b10:   raw = vec_q | wr_data;
      2'b11:   raw = vec_q & ~wr_data;
      default: raw = vec_q;
    endcase
  end

  always_comb begin
    drop   = 1'b0;
    mode_l = raw[1:0];
    if (DIRECT_ONLY) begin
      mode_l = 2'b00;
    end else if (raw[1]) begin
      if (MODE_POLICY == 0)      drop   = 1'b1;
      else if (MODE_POLICY == 1) mode_l = {1'b0, raw[0]};
      else                       mode_l = 2'b00;
    end
  end

  assign legal = (raw & ~LOW_MASK) | {{(XLEN-2){1'b0}}, mode_l};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          vec_q <= RST_LEGAL;
    else if (wr_en && wr_op != 2'b00 && !drop) vec_q <= legal;
  end

  assign rd_data = vec_q;

  logic [XLEN-1:0] base;
  assign base        = {vec_q[XLEN-1:2], 2'b00};
  assign trap_target = (trap_irq && vec_q[1:0] == 2'b01)
                     ? base + (XLEN'(trap_cause) << 2)
                     : base;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_q[1] && (!DIRECT_ONLY || !vec_q[0]));                                 // R7
  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_q & LOW_MASK & ~XLEN'(3)) == '0);                                      // R3
  AST_TGT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_target[1:0] == 2'b00);                                                 // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_op == 2'b00) |=> $stable(rd_data));                           // R2
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE_POLICY == 0 && !DIRECT_ONLY && wr_en && raw[1]) |=> $stable(rd_data)); // R4
  AST_EXC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_irq |-> (trap_target == (rd_data & ~XLEN'(3))));                      // R8

endmodule

// File: tb/tvec_reg_tb.sv
module tvec_reg_tb_top;
  localparam int XW = 32;
  localparam int CW = 6;
  localparam logic [XW-1:0] RV = 32'h0000_1ABC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_op = 2'b00;
  logic [XW-1:0] wr_data = '0;
  logic trap_irq = 1'b0;
  logic [CW-1:0] trap_cause = '0;
  logic [XW-1:0] rd [4];
  logic [XW-1:0] tg [4];

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tvec_reg #(.XLEN(XW), .CAUSE_W(CW), .RST_VEC(RV), .MODE_POLICY(0), .DIRECT_ONLY(1'b0), .ALIGN_LSB(6))
    dut_i (.clk, .rst_n, .wr_en, .wr_op, .wr_data, .rd_data(rd[0]), .trap_irq, .trap_cause, .trap_target(tg[0]));
  tvec_reg #(.XLEN(XW), .CAUSE_W(CW), .RST_VEC(RV), .MODE_POLICY(1), .DIRECT_ONLY(1'b0), .ALIGN_LSB(2))
    dut_clr (.clk, .rst_n, .wr_en, .wr_op, .wr_data, .rd_data(rd[1]), .trap_irq, .trap_cause, .trap_target(tg[1]));
  tvec_reg #(.XLEN(XW), .CAUSE_W(CW), .RST_VEC(RV), .MODE_POLICY(2), .DIRECT_ONLY(1'b0), .ALIGN_LSB(12))
    dut_frc (.clk, .rst_n, .wr_en, .wr_op, .wr_data, .rd_data(rd[2]), .trap_irq, .trap_cause, .trap_target(tg[2]));
  tvec_reg #(.XLEN(XW), .CAUSE_W(CW), .RST_VEC(RV), .MODE_POLICY(0), .DIRECT_ONLY(1'b1), .ALIGN_LSB(2))
    dut_dir (.clk, .rst_n, .wr_en, .wr_op, .wr_data, .rd_data(rd[3]), .trap_irq, .trap_cause, .trap_target(tg[3]));

  int pol [4] = '{0, 1, 2, 0};
  bit dir [4] = '{0, 0, 0, 1};
  int aln [4] = '{6, 2, 12, 2};
  logic [XW-1:0] model [4];

  function automatic logic [XW-1:0] legalize(input logic [XW-1:0] old, input logic [XW-1:0] r,
                                             input int p, input bit d, input int a);
    logic [1:0] m;
    logic [XW-1:0] msk;
    msk = (XW'(1) << a) - XW'(1);
    m = r[1:0];
    if (d) m = 2'b00;
    else if (r[1]) begin
      if (p == 0) return old;
      m = (p == 1) ? {1'b0, r[0]} : 2'b00;
    end
    return (r & ~msk) | XW'(m);
  endfunction

  function automatic string tag_of(input int k, input logic [XW-1:0] r);
    if (dir[k]) return "R7";
    if (!r[1]) return "R2/R3";
    if (pol[k] == 0) return "R4";
    if (pol[k] == 1) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input int k, input logic [XW-1:0] act, input logic [XW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s inst%0d act=%h exp=%h", req, k, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] op, input logic [XW-1:0] d);
    logic [XW-1:0] r;
    string t [4];
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    for (int k = 0; k < 4; k++) begin
      case (op)
        2'b01: r = d;
        2'b10: r = model[k] | d;
        2'b11: r = model[k] & ~d;
        default: r = model[k];
      endcase
      t[k] = (op == 2'b00) ? "R2" : tag_of(k, r);
      if (op != 2'b00) model[k] = legalize(model[k], r, pol[k], dir[k], aln[k]);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_op = 2'b00;
    for (int k = 0; k < 4; k++) check(t[k], k, rd[k], model[k]);
  endtask

  task automatic trap_sweep();
    logic [XW-1:0] e;
    for (int irq = 0; irq < 2; irq++)
      for (int c = 0; c < (1 << CW); c++) begin
        @(negedge clk);
        trap_irq = irq[0]; trap_cause = CW'(c);
        #1;
        for (int k = 0; k < 4; k++) begin
          e = model[k] & ~XW'(3);
          if (irq == 1 && model[k][1:0] == 2'b01) begin
            e = e + XW'(c) * 4;
            check("R9", k, tg[k], e);
          end else begin
            check("R8", k, tg[k], e);
          end
          check("R10", k, {30'd0, tg[k][1:0]}, '0);
        end
      end
  endtask

  initial begin
    #(5 * 150000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [XW-1:0] p;
    for (int k = 0; k < 4; k++) model[k] = RV & ~((XW'(1) << aln[k]) - XW'(1));
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) check("R1", k, rd[k], model[k]);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) check("R1", k, rd[k], model[k]);

    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 64; i++) begin
        p = (XW'(i) * 32'h9E37_79B1) ^ XW'(i);
        p[1:0] = i[1:0];
        do_write(op[1:0], p);
      end

    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      wr_en = i[0]; wr_op = 2'b00; wr_data = ~XW'(i);
      @(negedge clk);
      wr_en = 1'b0;
      for (int k = 0; k < 4; k++) check("R2", k, rd[k], model[k]);
    end

    do_write(2'b01, 32'h0000_2341);
    trap_sweep();
    do_write(2'b01, 32'h8001_57C3);
    trap_sweep();
    do_write(2'b01, 32'h0040_0000);
    trap_sweep();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule